// File: doc/BRIEF.md
# Block address translation matcher

This block maps an effective address onto a physical address through a small table of block translation entries. There are two independent sets of entries. Instruction fetches search one set, and loads and stores search the other. Each entry holds two 32-bit words. The upper word carries the effective block index, a block-length field and two validity bits, one for supervisor state and one for user state. The lower word carries the physical block number and a two-bit protection code.

A lookup is purely combinational. The address, the access kind and the privilege level are applied, and in the same cycle the block reports a hit, the physical address, the granted rights and a protection-fault flag. When nothing hits, all outputs stay at zero, so the surrounding logic can fall back to segment and page translation. Entries are loaded one word at a time through a single synchronous write port.

Top module: `blk_xlate`

## Requirements
- R1: After the asynchronous active-low reset, every stored word is zero, so no entry is valid and every lookup misses.
- R2: With `wr_en` high at a rising clock edge, `wr_data` is stored into entry `wr_idx` of set `wr_set` (0 = data set, 1 = instruction set). When `wr_half` is 0 it goes to the upper word, and when `wr_half` is 1 it goes to the lower word.
- R3: `acc` encodes the access kind: 00 is a load, 01 is a store, and 1x is an instruction fetch. A fetch searches only the instruction set. Loads and stores search only the data set.
- R4: An entry takes part in a lookup only if its upper-word bit 1 is set while `priv` is 1 (supervisor), or its upper-word bit 0 is set while `priv` is 0 (user).
- R5: Upper-word bits [12:2] form the block-length field, and they act as a mask on address bits [27:17]. A valid entry hits when `ea[31:28]` equals upper bits [31:28], and `ea[27:17]` with the mask bits cleared equals upper bits [27:17].
- R6: On a hit, `pa[31:28]` is lower-word bits [31:28]. `pa[27:17]` is `(ea[27:17] AND mask) OR lower[27:17]`. `pa[16:12]` is `ea[16:12]`, and `pa[11:0]` is zero.
- R7: Lower-word bits [1:0] are the protection code. Code 0 grants nothing, code 2 grants read, write and execute, and codes 1 and 3 grant read and execute. `prot` bit 0 means read, bit 1 means write and bit 2 means execute.
- R8: On a hit, `fault` is 1 exactly when the right the access needs is not in `prot`. A load needs read, a store needs write and a fetch needs execute.
- R9: When several entries hit, the lowest-numbered one alone sets `pa`, `prot` and `fault`.
- R10: On a miss, `hit`, `pa`, `prot` and `fault` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the write port |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_set | input | 1 | Target set: 0 data, 1 instruction |
| wr_idx | input | IW | Target entry index |
| wr_half | input | 1 | 0 upper word, 1 lower word |
| wr_data | input | 32 | Word to store |
| ea | input | 32 | Effective address to translate |
| acc | input | 2 | Access kind: 00 load, 01 store, 1x fetch |
| priv | input | 1 | 1 supervisor, 0 user |
| hit | output | 1 | An entry matched |
| pa | output | 32 | Translated physical address |
| prot | output | 3 | Granted rights {exec, write, read} |
| fault | output | 1 | Hit without the needed right |

## Verification
A bad stored word, or a wrong set or priority choice, shows at the ports in the same cycle as the lookup that touches that entry. The symptom is a hit turning into a miss, or a physical address taken from the wrong entry. A mask that is decoded in the wrong place shows only for addresses near the edge of a block. The bench therefore probes just inside and just outside a multi-size block. A wrong protection decode shows as a fault flag on an access that should pass, or no fault on one that should fail. Stores and fetches are tried against read-only and no-access entries to expose it.

// File: rtl/blk_xlate.sv
module blk_xlate #(
  parameter int N_ENT = 4,
  localparam int IW = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_set,
  input  logic [IW-1:0] wr_idx,
  input  logic          wr_half,
  input  logic [31:0]   wr_data,
  input  logic [31:0]   ea,
  input  logic [1:0]    acc,
  input  logic          priv,
  output logic          hit,
  output logic [31:0]   pa,
  output logic [2:0]    prot,
  output logic          fault
);

  logic [31:0] dhi [N_ENT];
  logic [31:0] dlo [N_ENT];
  logic [31:0] ihi [N_ENT];
  logic [31:0] ilo [N_ENT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N_ENT; k++) begin
        dhi[k] <= '0;
        dlo[k] <= '0;
        ihi[k] <= '0;
        ilo[k] <= '0;
      end
    end else if (wr_en) begin
      case ({wr_set, wr_half})
        2'b00: dhi[wr_idx] <= wr_data;
        2'b01: dlo[wr_idx] <= wr_data;
        2'b10: ihi[wr_idx] <= wr_data;
        default: ilo[wr_idx] <= wr_data;
      endcase
    end
  end

  wire is_fetch = acc[1];

  logic [N_ENT-1:0] match;
  logic [31:0]      pa_e [N_ENT];
  logic [1:0]       pp_e [N_ENT];

  genvar g;
  for (g = 0; g < N_ENT; g++) begin : g_ent
    wire [31:0] u  = is_fetch ? ihi[g] : dhi[g];
    wire [31:0] l  = is_fetch ? ilo[g] : dlo[g];
    wire [10:0] bl = u[12:2];
    wire        ok = priv ? u[1] : u[0];
    wire unused_ok = &{1'b0, u[16:13], l[16:2]};
    assign match[g] = ok && (ea[31:28] == u[31:28]) &&
                      ((ea[27:17] & ~bl) == u[27:17]);
    assign pa_e[g]  = {l[31:28], (ea[27:17] & bl) | l[27:17], ea[16:12], 12'h000};
    assign pp_e[g]  = l[1:0];
  end

  logic          found;
  logic [IW-1:0] win;

  always_comb begin
    found = 1'b0;
    win   = '0;
    for (int k = N_ENT - 1; k >= 0; k--) begin
      if (match[k]) begin
        found = 1'b1;
        win   = k[IW-1:0];
      end
    end
  end

  logic [2:0] rights;
  always_comb begin
    case (pp_e[win])
      2'd0:    rights = 3'b000;
      2'd2:    rights = 3'b111;
      default: rights = 3'b101;
    endcase
  end

  wire need_ok = is_fetch ? rights[2] : (acc[0] ? rights[1] : rights[0]);

  assign hit   = found;
  assign pa    = found ? pa_e[win] : 32'h0;
  assign prot  = found ? rights : 3'b000;
  assign fault = found && !need_ok;

  a_r8_fault_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> hit);

  a_r10_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (pa == 32'h0 && prot == 3'b000 && !fault));

  a_r6_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (pa[16:12] == ea[16:12] && pa[11:0] == 12'h000));

  a_r7_read_exec_paired: assert property (@(posedge clk) disable iff (!rst_n)
    prot[0] == prot[2]);

  a_r7_write_implies_read: assert property (@(posedge clk) disable iff (!rst_n)
    prot[1] |-> prot[0]);

endmodule

// File: tb/test_blk_xlate.sv
module test_blk_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_set = 1'b0, wr_half = 1'b0;
  logic [1:0]  wr_idx = '0;
  logic [31:0] wr_data = '0, ea = '0;
  logic [1:0]  acc = '0;
  logic        priv = 1'b0;
  logic        hit, fault;
  logic [31:0] pa;
  logic [2:0]  prot;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  blk_xlate #(.N_ENT(4)) i_blk_xlate (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_set(wr_set), .wr_idx(wr_idx),
    .wr_half(wr_half), .wr_data(wr_data), .ea(ea), .acc(acc), .priv(priv),
    .hit(hit), .pa(pa), .prot(prot), .fault(fault));

  task automatic wr(input logic s, input logic [1:0] idx, input logic half, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_set = s; wr_idx = idx; wr_half = half; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(input string tag, input logic [31:0] a, input logic [1:0] k, input logic p,
                      input logic eh, input logic [31:0] epa, input logic [2:0] epr, input logic ef);
    @(negedge clk);
    ea = a; acc = k; priv = p;
    #2;
    n_chk++;
    if (hit !== eh || pa !== epa || prot !== epr || fault !== ef) begin
      n_bad++;
      $display("FAIL %s: got hit=%b pa=%h prot=%b fault=%b, expected hit=%b pa=%h prot=%b fault=%b",
               tag, hit, pa, prot, fault, eh, epa, epr, ef);
    end
  endtask

  task automatic t_reset;
    look("R1 data after reset", 32'h1001_5678, 2'b00, 1'b1, 0, 32'h0, 3'b000, 0);
    look("R1 fetch after reset", 32'h0000_0000, 2'b10, 1'b0, 0, 32'h0, 3'b000, 0);
  endtask

  task automatic t_fill;
    wr(0, 0, 0, 32'h1000_0002); wr(0, 0, 1, 32'h8000_0002);
    wr(0, 1, 0, 32'h2000_1FFF); wr(0, 1, 1, 32'hA000_0001);
    wr(0, 2, 0, 32'h1000_0003); wr(0, 2, 1, 32'hC000_0002);
    wr(0, 3, 0, 32'h3008_000F); wr(0, 3, 1, 32'h4020_0000);
    wr(1, 0, 0, 32'h1000_0003); wr(1, 0, 1, 32'h5000_0001);
    wr(1, 1, 0, 32'h6000_0003); wr(1, 1, 1, 32'h7000_0000);
  endtask

  task automatic t_basic;
    look("R2 R6 small block load", 32'h1001_5678, 2'b00, 1'b1, 1, 32'h8001_5000, 3'b111, 0);
    look("R8 store on writable", 32'h1001_5678, 2'b01, 1'b1, 1, 32'h8001_5000, 3'b111, 0);
  endtask

  task automatic t_priv;
    look("R4 R9 user skips entry 0", 32'h1001_5678, 2'b00, 1'b0, 1, 32'hC001_5000, 3'b111, 0);
  endtask

  task automatic t_block;
    look("R5 R6 large block", 32'h2ABC_D123, 2'b00, 1'b0, 1, 32'hAABC_D000, 3'b101, 0);
    look("R5 masked block edge inside", 32'h300F_F000, 2'b00, 1'b1, 1, 32'h4027_F000, 3'b000, 1);
    look("R5 R10 just outside block", 32'h3010_0000, 2'b00, 1'b1, 0, 32'h0, 3'b000, 0);
    look("R10 no entry", 32'h5000_0000, 2'b01, 1'b1, 0, 32'h0, 3'b000, 0);
  endtask

  task automatic t_prot;
    look("R7 R8 store on read-only", 32'h2ABC_D123, 2'b01, 1'b1, 1, 32'hAABC_D000, 3'b101, 1);
    look("R7 R8 fetch on no-access", 32'h6000_1000, 2'b10, 1'b1, 1, 32'h7000_1000, 3'b000, 1);
  endtask

  task automatic t_sets;
    look("R3 fetch uses instr set", 32'h1001_5678, 2'b10, 1'b1, 1, 32'h5001_5000, 3'b101, 0);
    look("R3 fetch code 11", 32'h1001_5678, 2'b11, 1'b0, 1, 32'h5001_5000, 3'b101, 0);
    look("R3 fetch misses data-only block", 32'h2ABC_D123, 2'b10, 1'b0, 0, 32'h0, 3'b000, 0);
  endtask

  task automatic t_rewrite;
    wr(0, 0, 0, 32'h1000_0000);
    look("R2 R9 rewritten entry 0 yields to 2", 32'h1001_5678, 2'b00, 1'b1, 1, 32'hC001_5000, 3'b111, 0);
    wr(0, 2, 1, 32'hC000_0001);
    look("R2 lower word rewrite", 32'h1001_5678, 2'b01, 1'b1, 1, 32'hC001_5000, 3'b101, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fill();
    t_basic();
    t_priv();
    t_block();
    t_prot();
    t_sets();
    t_rewrite();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule